// File: doc/BRIEF.md
# Cache-coupled branch target buffer

This block predicts branch targets without storing any address tag. It hangs a small group of entries on every set of a set-associative instruction cache. In the fetch cycle it is read with the same set index as the cache. An entry is identified by the cache way that holds the branch and by the branch's slot within the line. The fetch stage supplies the way that hit in the cache and the offset taken from the PC. The block answers in the same cycle with a hit flag, the recorded target and a next-PC choice.

In the execute stage a resolved branch comes back with its set, its offset and the way index that was carried down the pipeline. A taken branch that has no entry yet gets one. The block prefers an empty entry of the set and otherwise evicts the least recently used one. A taken branch that already has an entry only refreshes its target. When the cache evicts a line, the cache tells the block the set and the way, and every entry of that set tied to that way is dropped.

Top module: `cc_btb`

## Requirements
- R1: After reset, or after a reset asserted in the middle of operation, every lookup misses and next_pc_o equals seq_pc_i.
- R2: A lookup hits in the same cycle only when lk_valid_i is high and an entry of set lk_set_i is valid and has both way equal to lk_way_i and offset equal to lk_off_i. A mismatch in way, in offset or in set is a miss, and target_o is zero on a miss.
- R3: next_pc_o is target_o when hit_o and pred_taken_i are both high, and seq_pc_i otherwise.
- R4: A taken update (upd_valid_i and upd_taken_i both high) for a branch with no entry writes exactly one entry. It fills the lowest-numbered empty entry of the set, and a lookup in the following cycle hits with the new target.
- R5: An update with upd_taken_i low writes nothing, and a later lookup of that branch misses.
- R6: A taken update for a branch that already has an entry overwrites that entry's target and never creates a second entry for the same way and offset.
- R7: When all entries of the set are valid, a taken update for a new branch replaces the least recently used entry. Both lookup hits and updates count as uses.
- R8: An invalidation (inv_valid_i) removes every entry of set inv_set_i whose way equals inv_way_i. It leaves other ways and other sets untouched.
- R9: If an update and an invalidation hit the same entry in the same cycle, the invalidation wins and the entry ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Fetch lookup request |
| lk_set_i | input | SET_W | Cache set index of the fetch PC |
| lk_way_i | input | WAY_W | Cache way that holds the fetched instruction |
| lk_off_i | input | OFF_W | Instruction slot within the line |
| pred_taken_i | input | 1 | Direction prediction for the fetched instruction |
| seq_pc_i | input | ADDR_W | Sequential next address |
| hit_o | output | 1 | Lookup hit |
| target_o | output | ADDR_W | Recorded target, zero on a miss |
| next_pc_o | output | ADDR_W | Selected next fetch address |
| upd_valid_i | input | 1 | Resolved branch report from execute |
| upd_taken_i | input | 1 | Branch resolved taken |
| upd_set_i | input | SET_W | Set of the resolved branch |
| upd_way_i | input | WAY_W | Way carried down from fetch |
| upd_off_i | input | OFF_W | Slot of the branch within its line |
| upd_target_i | input | ADDR_W | Resolved target |
| inv_valid_i | input | 1 | Cache line eviction notice |
| inv_set_i | input | SET_W | Set of the evicted line |
| inv_way_i | input | WAY_W | Way of the evicted line |

## Verification
The bench keeps the default build: sixteen sets, two cache ways, eight slots per line and two entries per set. With these values the single-bit replacement pointer is used, and a third taken branch in one set is enough to force an eviction. This shows whether the pointer follows lookups as well as writes. The two ways also let an eviction remove one branch while a branch in the other way at the same offset survives.

// File: rtl/cc_btb_pkg.sv
package cc_btb_pkg;
  typedef enum logic [1:0] {UPD_IDLE, UPD_REFRESH, UPD_ALLOC} upd_kind_e;
  typedef enum logic [1:0] {OP_LOOK, OP_UPD, OP_NT, OP_INV} tb_op_e;
endpackage

// File: rtl/cc_btb_array.sv
module cc_btb_array #(
  parameter int NUM_SETS = 16,
  parameter int WAY_W    = 1,
  parameter int OFF_W    = 3,
  parameter int TGT_W    = 32,
  parameter int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [WAY_W-1:0] lk_way_i,
  input  logic [OFF_W-1:0] lk_off_i,
  output logic             lk_hit_o,
  output logic [TGT_W-1:0] lk_tgt_o,
  input  logic [SET_W-1:0] up_set_i,
  input  logic [WAY_W-1:0] up_way_i,
  input  logic [OFF_W-1:0] up_off_i,
  output logic             up_vld_o,
  output logic             up_match_o,
  input  logic             we_i,
  input  logic [TGT_W-1:0] wr_tgt_i,
  input  logic             inv_valid_i,
  input  logic [SET_W-1:0] inv_set_i,
  input  logic [WAY_W-1:0] inv_way_i
);
  logic [NUM_SETS-1:0] vld_q, vld_d;
  logic [WAY_W-1:0]    way_q [NUM_SETS];
  logic [OFF_W-1:0]    off_q [NUM_SETS];
  logic [TGT_W-1:0]    tgt_q [NUM_SETS];
  logic [WAY_W-1:0]    inv_way_eff;

  assign lk_hit_o   = vld_q[lk_set_i] && (way_q[lk_set_i] == lk_way_i)
                      && (off_q[lk_set_i] == lk_off_i);
  assign lk_tgt_o   = tgt_q[lk_set_i];
  assign up_vld_o   = vld_q[up_set_i];
  assign up_match_o = up_vld_o && (way_q[up_set_i] == up_way_i)
                      && (off_q[up_set_i] == up_off_i);

  // eviction is judged against the way the entry holds after this cycle's write
  assign inv_way_eff = (we_i && up_set_i == inv_set_i) ? up_way_i : way_q[inv_set_i];

  always_comb begin
    vld_d = vld_q;
    if (we_i) vld_d[up_set_i] = 1'b1;
    if (inv_valid_i && inv_way_eff == inv_way_i) vld_d[inv_set_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      way_q[up_set_i] <= up_way_i;
      off_q[up_set_i] <= up_off_i;
      tgt_q[up_set_i] <= wr_tgt_i;
    end
  end
endmodule

// File: rtl/cc_btb_lru.sv
module cc_btb_lru #(
  parameter int NUM_SETS = 16,
  parameter int GROUPS   = 2,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int GW       = $clog2(GROUPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_touch_i,
  input  logic [SET_W-1:0]  lk_set_i,
  input  logic [GW-1:0]     lk_grp_i,
  input  logic              up_touch_i,
  input  logic [SET_W-1:0]  up_set_i,
  input  logic [GW-1:0]     up_grp_i,
  input  logic [GROUPS-1:0] up_vld_i,
  output logic [GW-1:0]     victim_o
);
  logic [GW-1:0] lru_grp;

  always_comb begin
    victim_o = lru_grp;
    for (int g = GROUPS - 1; g >= 0; g--)
      if (!up_vld_i[g]) victim_o = GW'(g);
  end

  if (GROUPS == 2) begin : g_ptr
    logic [NUM_SETS-1:0] ptr_q, ptr_d;
    assign lru_grp = ptr_q[up_set_i];
    always_comb begin
      ptr_d = ptr_q;
      if (lk_touch_i) ptr_d[lk_set_i] = ~lk_grp_i;
      if (up_touch_i) ptr_d[up_set_i] = ~up_grp_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q <= '0;
      else         ptr_q <= ptr_d;
    end
  end else begin : g_age
    logic [GW-1:0] age_q [NUM_SETS][GROUPS];
    always_comb begin
      lru_grp = '0;
      for (int g = 0; g < GROUPS; g++)
        if (age_q[up_set_i][g] == GW'(GROUPS - 1)) lru_grp = GW'(g);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < NUM_SETS; s++)
          for (int g = 0; g < GROUPS; g++) age_q[s][g] <= GW'(g);
      end else begin
        for (int s = 0; s < NUM_SETS; s++) begin
          logic          hit;
          logic [GW-1:0] tg;
          hit = 1'b0;
          tg  = '0;
          if (lk_touch_i && lk_set_i == SET_W'(s)) begin hit = 1'b1; tg = lk_grp_i; end
          if (up_touch_i && up_set_i == SET_W'(s)) begin hit = 1'b1; tg = up_grp_i; end
          if (hit)
            for (int g = 0; g < GROUPS; g++) begin
              if (GW'(g) == tg)                      age_q[s][g] <= '0;
              else if (age_q[s][g] < age_q[s][tg])  age_q[s][g] <= age_q[s][g] + 1'b1;
            end
        end
      end
    end
  end
endmodule

// File: rtl/cc_btb.sv
module cc_btb
  import cc_btb_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 2,
  parameter int LINE_INSNS = 8,
  parameter int GROUPS     = 2,
  parameter int ADDR_W     = 32,
  parameter int SET_W      = $clog2(NUM_SETS),
  parameter int WAY_W      = $clog2(NUM_WAYS),
  parameter int OFF_W      = $clog2(LINE_INSNS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [SET_W-1:0]  lk_set_i,
  input  logic [WAY_W-1:0]  lk_way_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  input  logic              pred_taken_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] next_pc_o,
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic [SET_W-1:0]  upd_set_i,
  input  logic [WAY_W-1:0]  upd_way_i,
  input  logic [OFF_W-1:0]  upd_off_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              inv_valid_i,
  input  logic [SET_W-1:0]  inv_set_i,
  input  logic [WAY_W-1:0]  inv_way_i
);
  localparam int GW = $clog2(GROUPS);

  logic [GROUPS-1:0] lk_match, up_match, up_vld, grp_we;
  logic [ADDR_W-1:0] lk_tgt [GROUPS];
  logic [GW-1:0]     lk_grp, up_grp, victim, wr_grp;
  logic [ADDR_W-1:0] sel_tgt;
  upd_kind_e         upd_kind;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    cc_btb_array #(
      .NUM_SETS(NUM_SETS), .WAY_W(WAY_W), .OFF_W(OFF_W), .TGT_W(ADDR_W)
    ) u_arr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_set_i   (lk_set_i),
      .lk_way_i   (lk_way_i),
      .lk_off_i   (lk_off_i),
      .lk_hit_o   (lk_match[g]),
      .lk_tgt_o   (lk_tgt[g]),
      .up_set_i   (upd_set_i),
      .up_way_i   (upd_way_i),
      .up_off_i   (upd_off_i),
      .up_vld_o   (up_vld[g]),
      .up_match_o (up_match[g]),
      .we_i       (grp_we[g]),
      .wr_tgt_i   (upd_target_i),
      .inv_valid_i(inv_valid_i),
      .inv_set_i  (inv_set_i),
      .inv_way_i  (inv_way_i)
    );
  end

  always_comb begin
    sel_tgt = '0;
    lk_grp  = '0;
    up_grp  = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (lk_match[g]) begin
        sel_tgt = sel_tgt | lk_tgt[g];
        lk_grp  = GW'(g);
      end
      if (up_match[g]) up_grp = GW'(g);
    end
  end

  assign hit_o     = lk_valid_i && (|lk_match);
  assign target_o  = hit_o ? sel_tgt : '0;
  assign next_pc_o = (hit_o && pred_taken_i) ? sel_tgt : seq_pc_i;

  always_comb begin
    if (!(upd_valid_i && upd_taken_i)) upd_kind = UPD_IDLE;
    else if (|up_match)                upd_kind = UPD_REFRESH;
    else                               upd_kind = UPD_ALLOC;
  end

  assign wr_grp = (upd_kind == UPD_REFRESH) ? up_grp : victim;

  always_comb
    for (int g = 0; g < GROUPS; g++)
      grp_we[g] = (upd_kind != UPD_IDLE) && (wr_grp == GW'(g));

  cc_btb_lru #(.NUM_SETS(NUM_SETS), .GROUPS(GROUPS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_touch_i(hit_o),
    .lk_set_i  (lk_set_i),
    .lk_grp_i  (lk_grp),
    .up_touch_i(upd_kind != UPD_IDLE),
    .up_set_i  (upd_set_i),
    .up_grp_i  (wr_grp),
    .up_vld_i  (up_vld),
    .victim_o  (victim)
  );
endmodule

// File: rtl/cc_btb_chk.sv
module cc_btb_chk #(
  parameter int GROUPS = 2,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [SET_W-1:0]  lk_set_i,
  input logic [WAY_W-1:0]  lk_way_i,
  input logic              hit_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic              inv_valid_i,
  input logic [SET_W-1:0]  inv_set_i,
  input logic [WAY_W-1:0]  inv_way_i,
  input logic [GROUPS-1:0] lk_match,
  input logic [GROUPS-1:0] grp_we
);
  a_r2_hit_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> lk_valid_i);

  a_r4_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |-> $onehot(grp_we));

  a_r5_not_taken_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_valid_i && upd_taken_i) |-> (grp_we == '0));

  a_r6_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  // R8, R9: a lookup right after an eviction notice never hits the evicted way
  a_r8_evicted_way_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inv_valid_i) && lk_valid_i && lk_set_i == $past(inv_set_i)
     && lk_way_i == $past(inv_way_i)) |-> !hit_o);
endmodule

bind cc_btb cc_btb_chk #(.GROUPS(GROUPS), .SET_W(SET_W), .WAY_W(WAY_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_valid_i (lk_valid_i),
  .lk_set_i   (lk_set_i),
  .lk_way_i   (lk_way_i),
  .hit_o      (hit_o),
  .upd_valid_i(upd_valid_i),
  .upd_taken_i(upd_taken_i),
  .inv_valid_i(inv_valid_i),
  .inv_set_i  (inv_set_i),
  .inv_way_i  (inv_way_i),
  .lk_match   (lk_match),
  .grp_we     (grp_we)
);

// File: tb/cc_btb_tb_top.sv
module cc_btb_tb_top;
  import cc_btb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEQ = 32'h0000_1000;

  typedef struct packed {
    tb_op_e      op;
    logic [3:0]  set;
    logic        way;
    logic [2:0]  off;
    logic [31:0] tgt;
    logic        pred;
    logic        exp_hit;
    logic [31:0] exp_tgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{OP_LOOK, 4'd3, 1'b0, 3'd7, 32'h0,   1'b1, 1'b0, 32'h0,   4'd1}, // R1 empty after reset
    '{OP_UPD,  4'd3, 1'b0, 3'd7, 32'h100, 1'b0, 1'b0, 32'h0,   4'd4}, // R4 alloc entry 0
    '{OP_LOOK, 4'd3, 1'b0, 3'd7, 32'h0,   1'b1, 1'b1, 32'h100, 4'd4}, // R4 visible next cycle
    '{OP_UPD,  4'd3, 1'b1, 3'd7, 32'h204, 1'b0, 1'b0, 32'h0,   4'd4}, // R4 alloc entry 1
    '{OP_UPD,  4'd3, 1'b1, 3'd7, 32'h208, 1'b0, 1'b0, 32'h0,   4'd6}, // R6 refresh
    '{OP_LOOK, 4'd3, 1'b1, 3'd7, 32'h0,   1'b0, 1'b1, 32'h208, 4'd6}, // R6 new target
    '{OP_LOOK, 4'd3, 1'b0, 3'd2, 32'h0,   1'b1, 1'b0, 32'h0,   4'd2}, // R2 offset mismatch
    '{OP_UPD,  4'd3, 1'b1, 3'd2, 32'h214, 1'b0, 1'b0, 32'h0,   4'd7}, // R7 full, evict w0/o7
    '{OP_LOOK, 4'd3, 1'b0, 3'd7, 32'h0,   1'b1, 1'b0, 32'h0,   4'd7}, // R7 evicted
    '{OP_LOOK, 4'd3, 1'b1, 3'd2, 32'h0,   1'b1, 1'b1, 32'h214, 4'd7}, // R7
    '{OP_LOOK, 4'd3, 1'b1, 3'd7, 32'h0,   1'b1, 1'b1, 32'h208, 4'd7}, // R7 survivor, now MRU
    '{OP_NT,   4'd4, 1'b0, 3'd1, 32'h400, 1'b0, 1'b0, 32'h0,   4'd5}, // R5 not taken
    '{OP_LOOK, 4'd4, 1'b0, 3'd1, 32'h0,   1'b1, 1'b0, 32'h0,   4'd5}, // R5
    '{OP_LOOK, 4'd5, 1'b1, 3'd7, 32'h0,   1'b1, 1'b0, 32'h0,   4'd2}, // R2 other set
    '{OP_UPD,  4'd3, 1'b0, 3'd5, 32'h230, 1'b0, 1'b0, 32'h0,   4'd7}, // R7 lookup-driven victim
    '{OP_LOOK, 4'd3, 1'b1, 3'd2, 32'h0,   1'b1, 1'b0, 32'h0,   4'd7}, // R7
    '{OP_LOOK, 4'd3, 1'b1, 3'd7, 32'h0,   1'b1, 1'b1, 32'h208, 4'd7}, // R7
    '{OP_LOOK, 4'd3, 1'b0, 3'd5, 32'h0,   1'b1, 1'b1, 32'h230, 4'd3}, // R3 taken -> target
    '{OP_INV,  4'd3, 1'b1, 3'd0, 32'h0,   1'b0, 1'b0, 32'h0,   4'd8}, // R8 drop way 1
    '{OP_LOOK, 4'd3, 1'b1, 3'd7, 32'h0,   1'b1, 1'b0, 32'h0,   4'd8}, // R8
    '{OP_LOOK, 4'd3, 1'b0, 3'd5, 32'h0,   1'b1, 1'b1, 32'h230, 4'd8}, // R8 other way kept
    '{OP_INV,  4'd9, 1'b0, 3'd0, 32'h0,   1'b0, 1'b0, 32'h0,   4'd8}, // R8 other set
    '{OP_LOOK, 4'd3, 1'b0, 3'd5, 32'h0,   1'b0, 1'b1, 32'h230, 4'd8}, // R8, R3 not taken
    '{OP_UPD,  4'd3, 1'b1, 3'd0, 32'h240, 1'b0, 1'b0, 32'h0,   4'd4}, // R4 free entry reused
    '{OP_LOOK, 4'd3, 1'b1, 3'd0, 32'h0,   1'b1, 1'b1, 32'h240, 4'd4}, // R4
    '{OP_LOOK, 4'd3, 1'b0, 3'd5, 32'h0,   1'b1, 1'b1, 32'h230, 4'd4}  // R4 no eviction
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0, pred_taken_i = 1'b0;
  logic [3:0]  lk_set_i = '0, upd_set_i = '0, inv_set_i = '0;
  logic        lk_way_i = 1'b0, upd_way_i = 1'b0, inv_way_i = 1'b0;
  logic [2:0]  lk_off_i = '0, upd_off_i = '0;
  logic [31:0] seq_pc_i = SEQ, upd_target_i = '0;
  logic        upd_valid_i = 1'b0, upd_taken_i = 1'b0, inv_valid_i = 1'b0;
  logic        hit_o;
  logic [31:0] target_o, next_pc_o;
  int          n_chk = 0, n_err = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  cc_btb dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid_i = 1'b0; upd_valid_i = 1'b0; upd_taken_i = 1'b0; inv_valid_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [3:0] s, input logic w, input logic [2:0] o,
                      input logic p, input logic eh, input logic [31:0] et);
    lk_valid_i = 1'b1; lk_set_i = s; lk_way_i = w; lk_off_i = o; pred_taken_i = p;
    #1;
    chk(req, "hit", 32'(hit_o), 32'(eh));
    chk(req, "target", target_o, et);
    chk(req, "next_pc", next_pc_o, (eh && p) ? et : SEQ);
  endtask

  task automatic upd(input logic tk, input logic [3:0] s, input logic w, input logic [2:0] o,
                     input logic [31:0] t);
    upd_valid_i = 1'b1; upd_taken_i = tk; upd_set_i = s; upd_way_i = w; upd_off_i = o;
    upd_target_i = t;
  endtask

  task automatic inv(input logic [3:0] s, input logic w);
    inv_valid_i = 1'b1; inv_set_i = s; inv_way_i = w;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    foreach (VECS[i]) begin
      @(negedge clk_i);
      idle();
      case (VECS[i].op)
        OP_LOOK: look($sformatf("R%0d", VECS[i].req), VECS[i].set, VECS[i].way, VECS[i].off,
                      VECS[i].pred, VECS[i].exp_hit, VECS[i].exp_tgt);
        OP_UPD:  upd(1'b1, VECS[i].set, VECS[i].way, VECS[i].off, VECS[i].tgt);
        OP_NT:   upd(1'b0, VECS[i].set, VECS[i].way, VECS[i].off, VECS[i].tgt);
        default: inv(VECS[i].set, VECS[i].way);
      endcase
    end

    // R9: new allocation and eviction of the same way in one cycle
    @(negedge clk_i); idle(); upd(1'b1, 4'd7, 1'b0, 3'd3, 32'h300); inv(4'd7, 1'b0);
    @(negedge clk_i); idle(); look("R9", 4'd7, 1'b0, 3'd3, 1'b1, 1'b0, 32'h0);
    // R8: eviction of the other way leaves the new entry in place
    @(negedge clk_i); idle(); upd(1'b1, 4'd7, 1'b1, 3'd3, 32'h310); inv(4'd7, 1'b0);
    @(negedge clk_i); idle(); look("R8", 4'd7, 1'b1, 3'd3, 1'b1, 1'b1, 32'h310);
    // R9: refresh of an existing entry loses to an eviction of its way
    @(negedge clk_i); idle(); upd(1'b1, 4'd3, 1'b0, 3'd5, 32'h250); inv(4'd3, 1'b0);
    @(negedge clk_i); idle(); look("R9", 4'd3, 1'b0, 3'd5, 1'b1, 1'b0, 32'h0);
    // R1: reset in the middle of operation clears everything
    @(negedge clk_i); idle(); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); look("R1", 4'd3, 1'b1, 3'd0, 1'b1, 1'b0, 32'h0);
    @(negedge clk_i); idle(); look("R1", 4'd7, 1'b1, 3'd3, 1'b1, 1'b0, 32'h0);
    @(negedge clk_i); idle();
    report();
    $finish;
  end
endmodule